// File: doc/BRIEF.md
# Memory-Mapped Parallel Port Unit

This block gives an 8-bit CPU bus four 8-bit parallel ports. Three of them, A, B and C, are bidirectional. Each pin of these ports has a direction bit that selects whether it drives its pad or listens to it. The fourth port, D, only samples its pins. Bit 6 of port D also works as a second external interrupt: a falling edge on that pin sets a sticky flag, and software clears the flag. Every pin input passes through a two-flop synchronizer before the bus reads it or the edge detector sees it.

The CPU reaches the unit through a 12-bit address and a one-cycle write strobe. Read data is combinational from the address. The registers sit in the lowest 16 addresses of the space. Direction registers can only be written, and a read of one returns all ones. The unit drives an output-data vector and an output-enable vector for each bidirectional port, and an interrupt request line that follows the flag.

Top module: `pio_ports`

## Requirements
- R1: After reset, every output-data bit, every output-enable bit, the interrupt flag and `irq2_o` are 0.
- R2: A write to address 0x000, 0x001 or 0x002 loads the output latch of port A, B or C, which appears on `pa_out`, `pb_out` or `pc_out` after the clock edge of the write.
- R3: A write to address 0x004, 0x005 or 0x006 loads the direction register of port A, B or C, which appears on `pa_oe`, `pb_oe` or `pc_oe`; a 1 bit makes that pin an output.
- R4: A read of address 0x004, 0x005 or 0x006 returns 0xFF, whatever the direction register holds.
- R5: A read of 0x000 to 0x002 returns, bit by bit, the output latch where the direction bit is 1 and the synchronized pin level where it is 0.
- R6: A read of 0x003 returns the synchronized levels of port D, and a write to 0x003 has no effect on any output or register.
- R7: A change on a pin input becomes visible to a bus read after two rising clock edges of synchronization and never sooner.
- R8: A falling edge of the synchronized port D bit 6 sets the interrupt flag, which reads as bit 7 of address 0x00A and drives `irq2_o`. A rising edge does not set the flag.
- R9: A write to 0x00A with bit 7 at 0 clears the flag, a write with bit 7 at 1 leaves it unchanged, and bits 6 to 0 of 0x00A read as 0.
- R10: A read of any other address (0x007 to 0x009, 0x00B to 0x00F, or anything above 0x00F) returns 0x00, and a write there changes no output or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output data |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output data |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output data |
| pc_oe | output | 8 | Port C output enables |
| pd_in | input | 8 | Port D pin levels (input only) |
| irq2_o | output | 1 | Second interrupt request, high while the flag is set |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are steady at each rising edge and that `bus_wr` is low during reset. The bench meets this by changing bus inputs only on the falling edge. The pin inputs may change at any time, because the synchronizer absorbs them. The bench therefore also changes pins on the falling edge, so that the two-edge latency it expects from R7 is exact.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 12;
    localparam int N_BIDIR = 3;
    localparam int IRQ_BIT = 6;
    localparam int FLAG_BIT = 7;

    localparam logic [ADDR_W-1:0] ADR_DATA_A = 12'h000;
    localparam logic [ADDR_W-1:0] ADR_DATA_B = 12'h001;
    localparam logic [ADDR_W-1:0] ADR_DATA_C = 12'h002;
    localparam logic [ADDR_W-1:0] ADR_DATA_D = 12'h003;
    localparam logic [ADDR_W-1:0] ADR_DIR_A  = 12'h004;
    localparam logic [ADDR_W-1:0] ADR_DIR_B  = 12'h005;
    localparam logic [ADDR_W-1:0] ADR_DIR_C  = 12'h006;
    localparam logic [ADDR_W-1:0] ADR_MISC   = 12'h00A;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] st;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.st[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.st[i] = s_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.st[STAGES-1];
endmodule

// File: rtl/pio_bidir_port.sv
module pio_bidir_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lat,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] rd_o
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_lat) p_d.lat = wdata;
        if (wr_dir) p_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_o = p_q.lat;
    assign oe_o  = p_q.dir;
    assign rd_o  = (p_q.lat & p_q.dir) | (pin_s & ~p_q.dir);
endmodule

// File: rtl/pio_edge_flag.sv
module pio_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic flag_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } ef_t;

    ef_t e_d, e_q;
    logic fall;

    always_comb begin
        fall = e_q.prev & ~lvl;
        e_d = e_q;
        e_d.prev = lvl;
        if (clr)  e_d.flag = 1'b0;
        if (fall) e_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign flag_o = e_q.flag;
endmodule

// File: rtl/pio_ports.sv
module pio_ports
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe,
    input  logic [DATA_W-1:0] pd_in,
    output logic              irq2_o
);
    localparam int NPORT = N_BIDIR + 1;

    logic [NPORT-1:0][DATA_W-1:0]   pin_raw, pin_s;
    logic [N_BIDIR-1:0][DATA_W-1:0] out_v, oe_v, rd_v;
    logic [N_BIDIR-1:0]             wr_lat, wr_dir;
    logic                           clr_flag, flag;

    assign pin_raw = {pd_in, pc_in, pb_in, pa_in};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_sync
            pio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst_n (rst_n),
                .din (pin_raw[g]),
                .dout (pin_s[g])
            );
        end

        for (genvar g = 0; g < N_BIDIR; g++) begin : g_port
            assign wr_lat[g] = bus_wr && (bus_addr == ADR_DATA_A + ADDR_W'(g));
            assign wr_dir[g] = bus_wr && (bus_addr == ADR_DIR_A + ADDR_W'(g));
            pio_bidir_port #(.W(DATA_W)) u_port (
                .clk (clk),
                .rst_n (rst_n),
                .wr_lat (wr_lat[g]),
                .wr_dir (wr_dir[g]),
                .wdata (bus_wdata),
                .pin_s (pin_s[g]),
                .out_o (out_v[g]),
                .oe_o (oe_v[g]),
                .rd_o (rd_v[g])
            );
        end
    endgenerate

    assign clr_flag = bus_wr && (bus_addr == ADR_MISC) && !bus_wdata[FLAG_BIT];

    pio_edge_flag u_flag (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (pin_s[N_BIDIR][IRQ_BIT]),
        .clr (clr_flag),
        .flag_o (flag)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_DATA_A: bus_rdata = rd_v[0];
            ADR_DATA_B: bus_rdata = rd_v[1];
            ADR_DATA_C: bus_rdata = rd_v[2];
            ADR_DATA_D: bus_rdata = pin_s[N_BIDIR];
            ADR_DIR_A, ADR_DIR_B, ADR_DIR_C: bus_rdata = '1;
            ADR_MISC:   bus_rdata[FLAG_BIT] = flag;
            default:    bus_rdata = '0;
        endcase
    end

    assign pa_out = out_v[0];
    assign pb_out = out_v[1];
    assign pc_out = out_v[2];
    assign pa_oe  = oe_v[0];
    assign pb_oe  = oe_v[1];
    assign pc_oe  = oe_v[2];
    assign irq2_o = flag;
endmodule

// File: rtl/pio_ports_chk.sv
module pio_ports_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_oe,
    input logic              irq2_o
);
    a_r2_lat_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_DATA_A) |=> (pa_out == $past(bus_wdata)));

    a_r2_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADR_DATA_A) |=> $stable(pa_out));

    a_r3_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_DIR_A) |=> (pa_oe == $past(bus_wdata)));

    a_r4_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_DIR_B) |-> (bus_rdata == 8'hFF));

    a_r9_misc_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_MISC) |-> (bus_rdata[6:0] == 7'd0 && bus_rdata[7] == irq2_o));

    a_r9_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq2_o) |-> $past(bus_wr && bus_addr == ADR_MISC && !bus_wdata[FLAG_BIT]));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 12'h00F) |-> (bus_rdata == 8'h00));

    a_r10_unmapped_no_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADR_DIR_B) |=> $stable(pb_oe));
endmodule

bind pio_ports pio_ports_chk u_chk (.*);

// File: tb/sim_pio_ports.sv
module sim_pio_ports;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pa_in = '0, pb_in = '0, pc_in = '0, pd_in = '0;
    logic [7:0]  pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic        irq2_o;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pio_ports u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe),
        .pd_in (pd_in), .irq2_o (irq2_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_out", pc_out, 8'h00);
        chk("R1 irq2", {7'd0, irq2_o}, 8'h00);
    endtask

    task automatic t_latch_dir;
        logic [7:0] v;
        wr(12'h000, 8'hA5); chk("R2 pa_out", pa_out, 8'hA5);
        wr(12'h001, 8'h3C); chk("R2 pb_out", pb_out, 8'h3C);
        wr(12'h002, 8'hF0); chk("R2 pc_out", pc_out, 8'hF0);
        chk("R2 pa_out unchanged", pa_out, 8'hA5);
        wr(12'h004, 8'h0F); chk("R3 pa_oe", pa_oe, 8'h0F);
        wr(12'h005, 8'hFF); chk("R3 pb_oe", pb_oe, 8'hFF);
        wr(12'h006, 8'h81); chk("R3 pc_oe", pc_oe, 8'h81);
        rd(12'h004, v); chk("R4 dir A read", v, 8'hFF);
        rd(12'h006, v); chk("R4 dir C read", v, 8'hFF);
    endtask

    task automatic t_mixed_read;
        logic [7:0] v;
        pa_in = 8'h5A; pb_in = 8'h00; pc_in = 8'h7E;
        wait_neg(3);
        rd(12'h000, v); chk("R5 port A mix", v, (8'hA5 & 8'h0F) | (8'h5A & 8'hF0));
        rd(12'h001, v); chk("R5 port B all out", v, 8'h3C);
        rd(12'h002, v); chk("R5 port C mix", v, (8'hF0 & 8'h81) | (8'h7E & 8'h7E));
    endtask

    task automatic t_sync;
        logic [7:0] v;
        wr(12'h004, 8'h00);
        @(negedge clk);
        bus_addr = 12'h000;
        pa_in = 8'hC3;
        @(negedge clk); #1 chk("R7 after 1 edge", bus_rdata, 8'h5A);
        @(negedge clk); #1 chk("R7 after 2 edges", bus_rdata, 8'hC3);
        pd_in = 8'h96;
        wait_neg(3);
        rd(12'h003, v); chk("R6 port D read", v, 8'h96);
        wr(12'h003, 8'h00);
        rd(12'h003, v); chk("R6 port D write ignored", v, 8'h96);
        chk("R6 pa_out kept", pa_out, 8'hA5);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        pd_in = 8'h00; wait_neg(4);
        wr(12'h00A, 8'h00);
        pd_in = 8'h40; wait_neg(5);
        chk("R8 rising no flag", {7'd0, irq2_o}, 8'h00);
        pd_in = 8'h00; wait_neg(5);
        chk("R8 falling sets irq", {7'd0, irq2_o}, 8'h01);
        rd(12'h00A, v); chk("R8 flag reads bit7", v, 8'h80);
        wr(12'h00A, 8'hFF);
        rd(12'h00A, v); chk("R9 write 1 keeps", v, 8'h80);
        wr(12'h00A, 8'h7F);
        rd(12'h00A, v); chk("R9 write 0 clears", v, 8'h00);
        chk("R9 irq low", {7'd0, irq2_o}, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(12'h008, 8'h55); wr(12'h105, 8'h00); wr(12'h100, 8'h11);
        chk("R10 pb_oe kept", pb_oe, 8'hFF);
        chk("R10 pa_out kept", pa_out, 8'hA5);
        rd(12'h008, v); chk("R10 read 008", v, 8'h00);
        rd(12'h00F, v); chk("R10 read 00F", v, 8'h00);
        rd(12'h104, v); chk("R10 read 104", v, 8'h00);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        t_reset;
        t_latch_dir;
        t_mixed_read;
        t_sync;
        t_irq;
        t_unmapped;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule